// File: doc/BRIEF.md
# One-Wire ROM Code CRC Checker

This block checks the 64-bit identification code that a one-wire temperature sensor returns. An upstream bus engine has already sampled the bits. It hands them over one at a time: a bit value together with a strobe, least significant bit first. While the bits arrive, the block runs the 8-bit one-wire check polynomial x^8 + x^5 + x^4 + 1 serially over them, in reflected form with a tap mask of 0x8C and a zero start value. It also keeps the low 56 bits of the code, which hold the device-class byte and the serial number.

When the 64th bit is taken, the block raises a one-cycle completion pulse. Two verdict flags are set at the same time. One says whether the check remainder over the full code is zero. The other says whether the device-class byte equals the value expected for this sensor type. The verdicts are kept apart, so a corrupted transfer can be told from a device of the wrong kind.

A clear input rearms the block for the next code. Strobes that arrive after the 64th bit and before a clear are dropped.

Top module: `owid_crc_checker`

## Requirements
- R1: After a synchronous reset (`rst` high for at least one rising edge), `done`, `crc_ok`, `family_ok`, `serial_no` and `family_code` are all zero.
- R2: The i-th accepted strobe carries bit i of the code (bit 0 first). Once 64 bits have been taken, `family_code` equals code bits 7:0 and `serial_no` equals code bits 55:8.
- R3: `crc_ok` is 1 exactly when the serial check over all 64 bits leaves a zero remainder. The check register starts at zero. Per bit, the incoming bit is XORed with register bit 0, the register shifts right, and 0x8C is XORed in when that XOR was 1. This is the same as the check over bits 55:0 equalling bits 63:56.
- R4: `family_ok` is 1 exactly when code bits 7:0 equal 0x28, whatever the check result.
- R5: `done` is high for exactly one cycle: the cycle after the rising edge that takes the 64th strobe. It is low before that.
- R6: `crc_ok` and `family_ok` are 0 until `done` rises. They then hold their values until the next clear or reset.
- R7: Strobes after the 64th bit and before a clear change no output and produce no further `done`.
- R8: `clr` high at a rising edge zeroes the bit count, the check register, both flags, `done` and the captured fields. A strobe in the same cycle as `clr` is not taken.
- R9: Cycles with `bit_vld` low leave the bit count and the captured fields unchanged, so gaps between strobes do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Rearm for a new code, synchronous, active high |
| bit_vld | input | 1 | Strobe: `bit_in` holds the next code bit |
| bit_in | input | 1 | Code bit value, least significant bit first |
| done | output | 1 | One-cycle pulse after the 64th bit |
| crc_ok | output | 1 | Check remainder over the code was zero |
| family_ok | output | 1 | Device-class byte equals the expected value |
| serial_no | output | 48 | Captured serial number, code bits 55:8 |
| family_code | output | 8 | Captured device-class byte, code bits 7:0 |

## Verification
All results come from one register stage behind the edge that takes the 64th strobe. `done`, both verdicts and the final captured fields are therefore due at the first falling edge after that strobe is presented, and `done` must be low again one cycle later. A clear takes effect at its own rising edge, so its zeroed outputs are read on the following falling edge. The bench drives strobes on falling edges, with random gaps between them. It samples at those fixed falling-edge points only, comparing against a check value and field split that the bench computes from the code word itself.

// File: rtl/owid_pkg.sv
package owid_pkg;

    // Code word layout: class byte at the bottom, check byte at the top
    localparam int unsigned CODE_BITS   = 64;
    localparam int unsigned CLASS_BITS  = 8;
    localparam int unsigned SERIAL_BITS = 48;
    localparam int unsigned CHECK_BITS  = CODE_BITS - CLASS_BITS - SERIAL_BITS;
    localparam int unsigned DATA_BITS   = CLASS_BITS + SERIAL_BITS;
    localparam int unsigned CNT_W       = $clog2(CODE_BITS + 1);

    // x^8 + x^5 + x^4 + 1, bit-reversed for right-shifting hardware
    localparam logic [CHECK_BITS-1:0] CHECK_TAPS   = 8'h8C;
    localparam logic [CLASS_BITS-1:0] CLASS_SENSOR = 8'h28;

    // Captured part of the code; bit order matches the wire order
    typedef struct packed {
        logic [SERIAL_BITS-1:0] serial;
        logic [CLASS_BITS-1:0]  dev_class;
    } owid_data_t;

    // Per-cycle control from the bit sequencer
    typedef struct packed {
        logic take;      // strobe accepted this cycle
        logic in_data;   // accepted bit belongs to the low 56 bits
        logic last;      // accepted bit is the final one
    } owid_step_t;

    typedef struct packed {
        logic done;
        logic crc_ok;
        logic family_ok;
    } owid_verdict_t;

endpackage

// File: rtl/owid_bit_seq.sv
module owid_bit_seq
    import owid_pkg::*;
#(
    parameter int unsigned TOTAL = CODE_BITS,
    parameter int unsigned KEEP  = DATA_BITS,
    localparam int unsigned CW   = $clog2(TOTAL + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       bit_vld,
    output owid_step_t step
);

    logic [CW-1:0] cnt_q;
    logic          full;

    assign full         = (cnt_q == CW'(TOTAL));
    assign step.take    = bit_vld && !clr && !full;
    assign step.in_data = step.take && (cnt_q < CW'(KEEP));
    assign step.last    = step.take && (cnt_q == CW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step.take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/owid_crc_serial.sv
module owid_crc_serial
    import owid_pkg::*;
#(
    parameter int unsigned          W    = CHECK_BITS,
    parameter logic [W-1:0]         TAPS = CHECK_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic         bit_in,
    output logic [W-1:0] rem_nxt
);

    logic [W-1:0] rem_q;
    logic         fb;

    assign fb = rem_q[0] ^ bit_in;

    // Right shift with feedback injected at every set tap
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            assign rem_nxt[i] = TAPS[i] & fb;
        end else begin : g_mid
            assign rem_nxt[i] = rem_q[i+1] ^ (TAPS[i] & fb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem_q <= '0;
        end else if (take) begin
            rem_q <= rem_nxt;
        end
    end

endmodule

// File: rtl/owid_shift_capture.sv
module owid_shift_capture
    import owid_pkg::*;
#(
    parameter int unsigned W = DATA_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);

    // Bits enter at the top and move down, so after W shifts
    // the first bit received sits at position 0
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {bit_in, q[W-1:1]};
        end
    end

endmodule

// File: rtl/owid_crc_checker.sv
module owid_crc_checker
    import owid_pkg::*;
#(
    parameter logic [CLASS_BITS-1:0] EXPECT_CLASS = CLASS_SENSOR
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   bit_vld,
    input  logic                   bit_in,
    output logic                   done,
    output logic                   crc_ok,
    output logic                   family_ok,
    output logic [SERIAL_BITS-1:0] serial_no,
    output logic [CLASS_BITS-1:0]  family_code
);

    owid_step_t              step;
    logic [CHECK_BITS-1:0]   rem_nxt;
    logic [DATA_BITS-1:0]    data_raw;
    owid_data_t              data_q;
    owid_verdict_t           verdict_q;

    owid_bit_seq #(
        .TOTAL (CODE_BITS),
        .KEEP  (DATA_BITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .bit_vld (bit_vld),
        .step    (step)
    );

    owid_crc_serial #(
        .W    (CHECK_BITS),
        .TAPS (CHECK_TAPS)
    ) u_crc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .take    (step.take),
        .bit_in  (bit_in),
        .rem_nxt (rem_nxt)
    );

    owid_shift_capture #(
        .W (DATA_BITS)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .shift_en (step.in_data),
        .bit_in   (bit_in),
        .q        (data_raw)
    );

    assign data_q = owid_data_t'(data_raw);

    // Class byte is complete long before the final bit, so both
    // verdicts can be latched on the edge that takes that bit
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            verdict_q <= '0;
        end else begin
            verdict_q.done <= step.last;
            if (step.last) begin
                verdict_q.crc_ok    <= (rem_nxt == '0);
                verdict_q.family_ok <= (data_q.dev_class == EXPECT_CLASS);
            end
        end
    end

    assign done        = verdict_q.done;
    assign crc_ok      = verdict_q.crc_ok;
    assign family_ok   = verdict_q.family_ok;
    assign serial_no   = data_q.serial;
    assign family_code = data_q.dev_class;

endmodule

// File: rtl/owid_crc_checker_sva.sv
module owid_crc_checker_sva
    import owid_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   clr,
    input logic                   bit_vld,
    input logic                   done,
    input logic                   crc_ok,
    input logic                   family_ok,
    input logic [SERIAL_BITS-1:0] serial_no,
    input logic [CLASS_BITS-1:0]  family_code
);

    logic seen_done;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_done <= 1'b0;
        end else if (done) begin
            seen_done <= 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((crc_ok || family_ok) && !clr) |=> ($stable(crc_ok) && $stable(family_ok))); // R6

    AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (!seen_done && !done) |-> (!crc_ok && !family_ok)); // R6

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!done && !crc_ok && !family_ok && family_code == '0 && serial_no == '0)); // R8

    AST_IGNORE_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (seen_done && !clr) |=> ($stable(serial_no) && $stable(family_code) && !done)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !clr) |=> ($stable(serial_no) && $stable(family_code))); // R9

endmodule

bind owid_crc_checker owid_crc_checker_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .bit_vld     (bit_vld),
    .done        (done),
    .crc_ok      (crc_ok),
    .family_ok   (family_ok),
    .serial_no   (serial_no),
    .family_code (family_code)
);

// File: tb/tb_owid_crc_checker.sv
module tb_owid_crc_checker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic        crc_ok;
    logic        family_ok;
    logic [47:0] serial_no;
    logic [7:0]  family_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    owid_crc_checker dut (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .done        (done),
        .crc_ok      (crc_ok),
        .family_ok   (family_ok),
        .serial_no   (serial_no),
        .family_code (family_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_check(input logic [55:0] d);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic m;
            m = r[0] ^ d[i];
            r = {1'b0, r[7:1]};
            if (m) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    function automatic logic [63:0] build_code(input logic [7:0] cls, input logic [47:0] ser);
        return {ref_check({ser, cls}), ser, cls};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Present all 64 bits; max_gap idle cycles may follow each strobe
    task automatic feed(input logic [63:0] code, input int max_gap);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i == 63) check("R5 done low before last bit", 64'(done), 64'd0);
            bit_vld = 1'b1;
            bit_in  = code[i];
            if (i < 63) begin
                int gap;
                gap = $urandom_range(0, max_gap);
                repeat (gap) begin
                    @(negedge clk);
                    bit_vld = 1'b0;
                    bit_in  = 1'($urandom);
                end
            end
        end
    endtask

    task automatic finish_check(input logic [63:0] code, input string tag);
        logic exp_crc;
        logic exp_cls;
        exp_crc = (ref_check(code[55:0]) == code[63:56]);
        exp_cls = (code[7:0] == 8'h28);
        @(negedge clk);
        bit_vld = 1'b0;
        check({"R5 done pulse ", tag}, 64'(done), 64'd1);
        check({"R2 class byte ", tag}, 64'(family_code), 64'(code[7:0]));
        check({"R2 serial ", tag}, 64'(serial_no), 64'(code[55:8]));
        check({"R3 crc_ok ", tag}, 64'(crc_ok), 64'(exp_crc));
        check({"R4 family_ok ", tag}, 64'(family_ok), 64'(exp_cls));
        @(negedge clk);
        check({"R5 done single cycle ", tag}, 64'(done), 64'd0);
        check({"R6 verdict held ", tag}, 64'({crc_ok, family_ok}), 64'({exp_crc, exp_cls}));
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        check("R8 clear zeroes", 64'({done, crc_ok, family_ok, serial_no, family_code}), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [63:0] code;
        void'($urandom(32'h0A51_7E3D));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 64'({done, crc_ok, family_ok, serial_no, family_code}), 64'd0);

        // Known-good code
        code = build_code(8'h28, 48'h0000_0A1B_2C3D);
        feed(code, 0);
        finish_check(code, "good");

        // R7: extra strobes after completion are dropped
        repeat (6) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = 1'($urandom);
        end
        @(negedge clk);
        bit_vld = 1'b0;
        @(negedge clk);
        check("R7 no second done", 64'(done), 64'd0);
        check("R7 fields unchanged", 64'({serial_no, family_code}), 64'(code[55:0]));
        check("R7 verdicts unchanged", 64'({crc_ok, family_ok}), 64'b11);

        // R6: verdicts persist over idle time
        repeat (10) @(negedge clk);
        check("R6 verdicts after idle", 64'({crc_ok, family_ok}), 64'b11);

        // One serial bit flipped: check fails, class still right
        do_clear();
        code = build_code(8'h28, 48'h1234_5678_9ABC) ^ (64'h1 << 20);
        feed(code, 1);
        finish_check(code, "flipped serial bit");
        check("R3 flipped bit rejected", 64'(crc_ok), 64'd0);

        // Wrong class byte with a consistent check byte
        do_clear();
        code = build_code(8'h10, 48'hFEDC_BA98_7654);
        feed(code, 2);
        finish_check(code, "wrong class");
        check("R4 wrong class flagged alone", 64'({crc_ok, family_ok}), 64'b10);

        // All-zero code: zero remainder, wrong class
        do_clear();
        feed(64'd0, 0);
        finish_check(64'd0, "all zero");

        // R8: clear mid-stream, with a strobe in the same cycle
        do_clear();
        code = build_code(8'h28, 48'h5555_AAAA_0F0F);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = ~code[i];
        end
        @(negedge clk);
        clr = 1'b1;
        bit_vld = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        bit_vld = 1'b0;
        check("R8 clear with strobe", 64'({serial_no, family_code}), 64'd0);
        feed(code, 0);
        finish_check(code, "after mid clear");

        // R9 gaps and mixed codes
        for (int t = 0; t < 40; t++) begin
            logic [7:0]  cls;
            logic [47:0] ser;
            cls = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h28;
            ser = {16'($urandom), 32'($urandom)};
            code = build_code(cls, ser);
            if ($urandom_range(0, 2) == 0) code = code ^ (64'h1 << $urandom_range(0, 63));
            do_clear();
            feed(code, 3);
            finish_check(code, "R9 random gapped");
        end

        summary();
    end

endmodule